// File: doc/BRIEF.md
# Two-Wire Register Slave with Byte and Block Access

This block is a serial slave for a two-wire host bus (SMBus style). It sits on oversampled copies of the SCL and SDA lines and owns a small bank of eight 8-bit control registers. The host reaches the bank through four transfer types: single-byte write, single-byte read, block write and block read. Bit 7 of the command byte picks byte access (offset in bits 6:0) or block access (always starting at offset 0). The slave pulls SDA low only through an open-drain enable output.

Every register bit is driven continuously to downstream logic. A few bits are read-only and mirror strap values that are latched outside the block. One writable bit switches block writes into plain mode, where no byte-count byte is sent. Both lines pass through a two-flop synchroniser and are then edge-detected in the system clock domain, so the system clock must run several times faster than SCL.

Top module: `smb_reg_slave`

## Requirements
- R1: After rst_ni is released, regs_o holds the defaults, offsets 0..7 = 1F, FE, FF, 00, 00, 00, 18, 08 (hex; offset k sits at regs_o[8k+7:8k]), except offset 6 bits 2:0, which follow strap_i.
- R2: After any received byte that is addressed to the slave, the slave holds SDA low through the ninth SCL clock. It changes sda_oe_o only while SCL is low.
- R3: The slave answers only the address byte D2h (write) or D3h (read). After any other address it does not acknowledge, leaves every register untouched and ignores the bus until the next START.
- R4: A byte write (D2h, command with bit 7 = 1 and offset in bits 6:0, one data byte) updates the register at that offset.
- R5: A byte read (D2h, command with bit 7 = 1, repeated START, D3h) returns the register at the offset, MSB first, and the master ends it with a NACK.
- R6: A block write (D2h, command 00h, one byte-count byte, then data) acknowledges the count byte and discards its value. The data bytes go to offsets 0, 1, 2, … in order, and a STOP after any whole byte keeps the bytes written so far.
- R7: When offset 5 bit 0 is 1 (plain mode), a block write carries no count byte, and the first byte after the command goes to offset 0.
- R8: A block read (D2h, command 00h, repeated START, D3h) first returns 08h, then offsets 0, 1, 2, …. Each master ACK fetches the next byte, and a NACK ends the transfer.
- R9: Writes change only the writable bits. These are, per offset 0..7: 1F, F7, FF, FF, F0, 61, D8, 00. Writes to offsets 8 and above change nothing, and reads of those offsets return 00h.
- R10: Offset 6 bits 2:0 always read back as the current value of strap_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line (sensed) |
| sda_oe_o | output | 1 | When 1, pull SDA low |
| strap_i | input | 3 | Externally latched read-only bits |
| regs_o | output | 64 | All eight registers, offset k at bits 8k+7:8k |

## Verification
Two actions share a single SCL falling edge: the slave commits a received data byte into the bank, and it starts driving the acknowledge. On that same edge the write pointer also advances. The bench provokes this with byte writes and with block writes of several bytes, in both counted mode and plain mode. After each STOP it compares the full register vector and every sampled ACK bit against a model built only from the masks and defaults. A write commit that lands at the wrong offset, a missing acknowledge, or a count byte taken as data each shows up as a mismatch.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned PTR_W  = 7;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_CMD, ST_CACK, ST_CNT, ST_KACK,
    ST_WDAT, ST_WACK, ST_RDAT, ST_RACK, ST_IGN
  } smb_state_e;
endpackage

// File: rtl/smb_sync.sv
module smb_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_q  <= scl_ff[1];
      sda_q  <= sda_ff[1];
    end
  end

  assign scl_o   = scl_ff[1];
  assign sda_o   = sda_ff[1];
  assign start_o = scl_q & scl_ff[1] & sda_q & ~sda_ff[1];
  assign stop_o  = scl_q & scl_ff[1] & ~sda_q & sda_ff[1];
  assign rise_o  = ~scl_q & scl_ff[1];
  assign fall_o  = scl_q & ~scl_ff[1];
endmodule

// File: rtl/smb_bus_fsm.sv
module smb_bus_fsm
  import smb_pkg::*;
#(
  parameter logic [6:0]  ADDR7 = 7'h69,
  parameter int unsigned NREG  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_s_i,
  input  logic              sda_s_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              plain_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic [PTR_W-1:0]  rd_addr_o,
  output logic              wr_en_o,
  output logic [PTR_W-1:0]  wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              sda_oe_o
);
  localparam logic [BYTE_W-1:0] CNT_BYTE = BYTE_W'(NREG);

  smb_state_e        state_q;
  logic [3:0]        bcnt_q;
  logic [BYTE_W-1:0] sh_q, tx_q, wr_data_q;
  logic [PTR_W-1:0]  ptr_q, wr_addr_q;
  logic              blk_q, rd_q, cntph_q, mack_q, wr_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bcnt_q    <= '0;
      sh_q      <= '0;
      tx_q      <= '0;
      ptr_q     <= '0;
      blk_q     <= 1'b0;
      rd_q      <= 1'b0;
      cntph_q   <= 1'b0;
      mack_q    <= 1'b0;
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      wr_en_q <= 1'b0;
      if (start_i) begin
        state_q <= ST_ADDR;
        bcnt_q  <= '0;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
      end else begin
        case (state_q)
          ST_ADDR, ST_CMD, ST_CNT, ST_WDAT: begin
            if (rise_i) begin
              sh_q   <= {sh_q[BYTE_W-2:0], sda_s_i};
              bcnt_q <= bcnt_q + 4'd1;
            end else if (fall_i && bcnt_q == 4'd8) begin
              bcnt_q <= '0;
              case (state_q)
                ST_ADDR: begin
                  if (sh_q[7:1] == ADDR7) begin
                    state_q <= ST_AACK;
                    rd_q    <= sh_q[0];
                  end else begin
                    state_q <= ST_IGN;
                  end
                end
                ST_CMD: begin
                  state_q <= ST_CACK;
                  blk_q   <= ~sh_q[7];
                  ptr_q   <= sh_q[7] ? sh_q[6:0] : '0;
                end
                ST_CNT: state_q <= ST_KACK;
                default: begin
                  state_q   <= ST_WACK;
                  wr_en_q   <= 1'b1;
                  wr_addr_q <= ptr_q;
                  wr_data_q <= sh_q;
                  ptr_q     <= ptr_q + 7'd1;
                end
              endcase
            end
          end
          ST_AACK: if (fall_i) begin
            if (rd_q) begin
              state_q <= ST_RDAT;
              cntph_q <= blk_q;
              tx_q    <= blk_q ? CNT_BYTE : rd_data_i;
            end else begin
              state_q <= ST_CMD;
            end
          end
          ST_CACK: if (fall_i) state_q <= (blk_q && !plain_i) ? ST_CNT : ST_WDAT;
          ST_KACK, ST_WACK: if (fall_i) state_q <= ST_WDAT;
          ST_RDAT: if (fall_i) begin
            if (bcnt_q == 4'd7) begin
              state_q <= ST_RACK;
              bcnt_q  <= '0;
            end else begin
              tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
              bcnt_q <= bcnt_q + 4'd1;
            end
          end
          ST_RACK: begin
            if (rise_i) mack_q <= ~sda_s_i;
            else if (fall_i) begin
              if (mack_q) begin
                state_q <= ST_RDAT;
                tx_q    <= rd_data_i;
                if (cntph_q) cntph_q <= 1'b0;
                else         ptr_q   <= ptr_q + 7'd1;
              end else begin
                state_q <= ST_IGN;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // next byte is fetched during the master acknowledge slot
  assign rd_addr_o = (state_q == ST_RACK && !cntph_q) ? ptr_q + 7'd1 : ptr_q;
  assign wr_en_o   = wr_en_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;
  assign sda_oe_o  = (state_q == ST_AACK) || (state_q == ST_CACK) ||
                     (state_q == ST_KACK) || (state_q == ST_WACK) ||
                     (state_q == ST_RDAT && !tx_q[7]);

  assert_sda_moves_scl_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_s_i);
  assert_release_on_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !sda_oe_o);
  assert_commit_on_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(fall_i));
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
  import smb_pkg::*;
#(
  parameter int unsigned          NREG      = 8,
  parameter logic [NREG*8-1:0]    DEFAULTS  = 64'h08_18_00_00_00_FF_FE_1F,
  parameter logic [NREG*8-1:0]    WMASK     = 64'h00_D8_61_F0_FF_FF_F7_1F,
  parameter int unsigned          STRAP_REG = 6,
  parameter int unsigned          STRAP_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [PTR_W-1:0]   wr_addr_i,
  input  logic [BYTE_W-1:0]  wr_data_i,
  input  logic [PTR_W-1:0]   rd_addr_i,
  output logic [BYTE_W-1:0]  rd_data_o,
  input  logic [STRAP_W-1:0] strap_i,
  output logic [NREG*8-1:0]  regs_o
);
  localparam int unsigned VW = NREG * 8;
  localparam int unsigned IW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [VW-1:0] STRAP_MASK = {{(VW-STRAP_W){1'b0}}, {STRAP_W{1'b1}}} << (STRAP_REG * 8);

  logic [VW-1:0] store_vec, strap_vec;
  logic [IW-1:0] rd_idx;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [7:0] M = WMASK[g*8 +: 8];
    logic [7:0] r_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   r_q <= DEFAULTS[g*8 +: 8];
      else if (wr_en_i && wr_addr_i == PTR_W'(g))    r_q <= (wr_data_i & M) | (r_q & ~M);
    end
    assign store_vec[g*8 +: 8] = r_q;
  end

  assign strap_vec = {{(VW-STRAP_W){1'b0}}, strap_i} << (STRAP_REG * 8);
  assign regs_o    = (store_vec & ~STRAP_MASK) | strap_vec;
  assign rd_idx    = rd_addr_i[IW-1:0];
  assign rd_data_o = (rd_addr_i < PTR_W'(NREG)) ? regs_o[8*rd_idx +: 8] : '0;

  assert_oor_write_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i >= PTR_W'(NREG)) |=> $stable(store_vec));
  assert_ro_bits_kept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> ((store_vec & ~WMASK) == ($past(store_vec) & ~WMASK)));
endmodule

// File: rtl/smb_reg_slave.sv
module smb_reg_slave
  import smb_pkg::*;
#(
  parameter logic [6:0]        ADDR7     = 7'h69,
  parameter int unsigned       NREG      = 8,
  parameter logic [NREG*8-1:0] DEFAULTS  = 64'h08_18_00_00_00_FF_FE_1F,
  parameter logic [NREG*8-1:0] WMASK     = 64'h00_D8_61_F0_FF_FF_F7_1F,
  parameter int unsigned       STRAP_REG = 6,
  parameter int unsigned       STRAP_W   = 3,
  parameter int unsigned       PLAIN_REG = 5,
  parameter int unsigned       PLAIN_BIT = 0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic [STRAP_W-1:0] strap_i,
  output logic [NREG*8-1:0]  regs_o
);
  logic scl_s, sda_s, start, stop, rise, fall;
  logic wr_en;
  logic [PTR_W-1:0]  wr_addr, rd_addr;
  logic [BYTE_W-1:0] wr_data, rd_data;

  smb_sync i_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .start_o(start), .stop_o(stop),
    .rise_o(rise), .fall_o(fall)
  );

  smb_bus_fsm #(.ADDR7(ADDR7), .NREG(NREG)) i_fsm (
    .clk_i, .rst_ni, .scl_s_i(scl_s), .sda_s_i(sda_s),
    .start_i(start), .stop_i(stop), .rise_i(rise), .fall_i(fall),
    .plain_i(regs_o[PLAIN_REG*8 + PLAIN_BIT]),
    .rd_data_i(rd_data), .rd_addr_o(rd_addr),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .sda_oe_o
  );

  smb_reg_bank #(
    .NREG(NREG), .DEFAULTS(DEFAULTS), .WMASK(WMASK),
    .STRAP_REG(STRAP_REG), .STRAP_W(STRAP_W)
  ) i_bank (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .strap_i, .regs_o
  );
endmodule

// File: tb/test_smb_reg_slave.sv
module test_smb_reg_slave;
  localparam int Q = 10;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic [2:0]  strap = 3'b101;
  logic        sda_oe, sda_line;
  logic [63:0] regs;

  assign sda_line = sda_m & ~sda_oe;
  always #4 clk = ~clk;

  smb_reg_slave i_smb_reg_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .strap_i(strap), .regs_o(regs)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] mdl [8];
  logic [7:0] exp_q [$];
  logic [7:0] act_q [$];
  string      tag_q [$];

  function automatic logic [7:0] dflt(int i);
    logic [63:0] d = 64'h08_18_00_00_00_FF_FE_1F;
    return d[i*8 +: 8];
  endfunction
  function automatic logic [7:0] wmask(int i);
    logic [63:0] m = 64'h00_D8_61_F0_FF_FF_F7_1F;
    return m[i*8 +: 8];
  endfunction
  function automatic logic [7:0] exp_reg(int i);
    return (i == 6) ? ((mdl[6] & 8'hF8) | {5'd0, strap}) : mdl[i];
  endfunction
  function automatic logic [63:0] exp_all();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[i*8 +: 8] = exp_reg(i);
    return v;
  endfunction
  function automatic void apply(int off, logic [7:0] val);
    if (off < 8) mdl[off] = (val & wmask(off)) | (mdl[off] & ~wmask(off));
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (act_q.size() > 0) begin
      logic [7:0] a, e;
      string t;
      a = act_q.pop_front();
      if (exp_q.size() > 0) begin e = exp_q.pop_front(); t = tag_q.pop_front(); end
      else begin e = 8'hxx; t = "scoreboard underflow"; end
      check(t, {56'd0, a}, {56'd0, e});
    end
  end

  task automatic wq(int n); repeat (n) @(negedge clk); endtask
  task automatic bit_w(input logic b);
    sda_m = b; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
  endtask
  task automatic bit_r(output logic b);
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); b = sda_line; wq(Q); scl = 1'b0; wq(Q);
  endtask
  task automatic bstart();
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl = 1'b0; wq(Q);
  endtask
  task automatic bstop();
    sda_m = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b1; wq(2*Q);
  endtask
  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) bit_w(d[i]);
    bit_r(b);
    ack = ~b;
  endtask
  task automatic rbyte(output logic [7:0] d, input logic nack);
    for (int i = 7; i >= 0; i--) bit_r(d[i]);
    bit_w(nack);
  endtask
  task automatic wack(logic [7:0] d, logic want, string tag);
    logic a;
    wbyte(d, a);
    check(tag, {63'd0, a}, {63'd0, want});
  endtask

  task automatic bwrite(logic [6:0] off, logic [7:0] val);
    bstart(); wack(8'hD2, 1'b1, "R2 addr ack"); wack({1'b1, off}, 1'b1, "R2 cmd ack");
    wack(val, 1'b1, "R2 data ack"); bstop();
    apply(int'(off), val);
  endtask

  task automatic bread(logic [6:0] off, string tag);
    logic [7:0] d;
    bstart(); wack(8'hD2, 1'b1, "R2 addr ack"); wack({1'b1, off}, 1'b1, "R2 cmd ack");
    bstart(); wack(8'hD3, 1'b1, "R2 read addr ack");
    exp_q.push_back(off < 8 ? exp_reg(int'(off)) : 8'h00); tag_q.push_back(tag);
    rbyte(d, 1'b1); act_q.push_back(d); bstop();
  endtask

  task automatic blkw(logic [7:0] d [], bit with_cnt, string tag);
    bstart(); wack(8'hD2, 1'b1, "R2 addr ack"); wack(8'h00, 1'b1, "R2 cmd ack");
    if (with_cnt) wack(8'hE7, 1'b1, {tag, " count ack"});
    foreach (d[i]) begin
      wack(d[i], 1'b1, {tag, " data ack"});
      apply(i, d[i]);
    end
    bstop();
  endtask

  task automatic blkr(int n, string tag);
    logic [7:0] d;
    bstart(); wack(8'hD2, 1'b1, "R2 addr ack"); wack(8'h00, 1'b1, "R2 cmd ack");
    bstart(); wack(8'hD3, 1'b1, "R2 read addr ack");
    exp_q.push_back(8'h08); tag_q.push_back({tag, " count"});
    rbyte(d, 1'b0); act_q.push_back(d);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(exp_reg(i)); tag_q.push_back({tag, " data"});
      rbyte(d, i == n - 1); act_q.push_back(d);
    end
    bstop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired (R1..all pending)");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) mdl[i] = dflt(i);
    wq(5); rst_n = 1'b1; wq(5);
    check("R1 reset defaults", regs, exp_all());
    check("R10 strap in reg6", {61'd0, regs[50:48]}, {61'd0, strap});

    bwrite(7'd2, 8'h5A);
    check("R4 byte write", regs, exp_all());
    bread(7'd2, "R5 byte read reg2");
    bread(7'd7, "R5 byte read reg7");
    bread(7'd6, "R10 read strap bits");

    // wrong address: no ack, rest of frame ignored
    bstart();
    wack(8'hD4, 1'b0, "R3 no ack on mismatch");
    wack(8'h83, 1'b0, "R3 ignored cmd");
    wack(8'h77, 1'b0, "R3 ignored data");
    bstop();
    check("R3 regs untouched", regs, exp_all());

    blkw('{8'h11, 8'h22, 8'h33}, 1'b1, "R6");
    check("R6 block write with count", regs, exp_all());

    bwrite(7'd7, 8'hFF);
    bwrite(7'd6, 8'hFF);
    check("R9 masked writes", regs, exp_all());
    bwrite(7'h10, 8'hAB);
    check("R9 out-of-range write", regs, exp_all());
    bread(7'h10, "R9 out-of-range read");

    blkr(8, "R8 full block read");
    blkr(1, "R8 early nack");

    bwrite(7'd5, 8'hFF);
    check("R9 plain bit write", regs, exp_all());
    blkw('{8'h05, 8'h06}, 1'b0, "R7");
    check("R7 plain block write", regs, exp_all());
    blkr(2, "R8 block read in plain mode");

    strap = 3'b010; wq(5);
    check("R10 strap follows input", regs, exp_all());
    bread(7'd6, "R10 strap read back");

    wq(20);
    done = 1;
    summary();
    $finish;
  end
endmodule